// File: doc/BRIEF.md
# Half-Bridge Gate Signal Conditioner

This block turns one or two logic PWM inputs into the upper and lower gate commands of a half-bridge power stage. A mode input selects one of three input arrangements. In the two single-input arrangements only the first PWM input is used and the block builds a complementary pair from it. The buck and boost variants differ only in which switch receives the true sense of that input. In the dual-input arrangement each input feeds its own gate path, with no interlock between them.

Each path has its own inversion bit and its own turn-on delay, counted in cycles of the fast system clock. The delay holds back rising gate edges only. A three-way bypass selector picks full conditioning, inversion only, or a raw copy of the two inputs. The block also watches the PWM inputs and raises one-cycle flags for high pulses that are too short, and for low pulses that are too short to recharge the high-side bootstrap supply. A configuration that is not allowed holds both gates low and leaves a sticky error flag.

Top module: `hb_gate_cond`

## Requirements
- R1: Reset drives gate_up, gate_lo, cfg_err and all short-pulse flags low and sets both turn-on delays to DT_RST (10 cycles). Each gate output is a register, so the earliest change comes one clock edge after the inputs change.
- R2: With mode = 0 (single buck), the upper path follows pwm_a and the lower path follows its complement.
- R3: With mode = 1 (single boost), the lower path follows pwm_a and the upper path follows its complement.
- R4: With mode = 2 (dual), pwm_a feeds the upper path and pwm_b feeds the lower path, and both gates may be high at the same time.
- R5: When bypass is 0 or 1, inv_up = 1 inverts the upper path and inv_lo = 1 inverts the lower path; a value of 0 leaves the path unchanged.
- R6: With bypass = 0, a path's gate rises on the dt-th consecutive clock edge at which its conditioned input is high, where dt is that path's own delay. It falls at the first edge at which that input is low.
- R7: A delay value loaded through dt_up_cfg or dt_lo_cfg is clamped to the range DT_MIN (5) to DT_MAX (15).
- R8: A dt_load pulse updates both delays only when gate_up and gate_lo are both low. Otherwise it is ignored.
- R9: A pending turn-on is dropped if the path input falls before the delay expires. In single-input modes with inv_up equal to inv_lo, the two gates are never high together.
- R10: With bypass = 1 (delay bypass), the gates follow the inverted or non-inverted path inputs after one register stage and have no turn-on delay.
- R11: With bypass = 2 (full bypass), gate_up copies pwm_a and gate_lo copies pwm_b. The inversion bits are ignored.
- R12: A single-input mode combined with bypass other than 0, or a mode or bypass value of 3, forces both gates low. The same condition sets cfg_err, which stays set until reset.
- R13: In single-input modes, pwm_b has no effect on the gates and raises no short-pulse flag.
- R14: short_hi[i] pulses for one cycle when input i (0 = pwm_a, 1 = pwm_b) ends a high run shorter than MIN_HI_CYC (50) cycles. short_lo[i] pulses when input i ends a low run shorter than MIN_LO_CYC (200) cycles. pwm_b is watched only in dual mode, and the first edge after reset is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_a | input | 1 | First PWM input |
| pwm_b | input | 1 | Second PWM input, used in dual mode |
| mode | input | 2 | 0 single buck, 1 single boost, 2 dual, 3 invalid |
| bypass | input | 2 | 0 full conditioning, 1 delay bypass, 2 full bypass, 3 invalid |
| inv_up | input | 1 | Upper path inversion |
| inv_lo | input | 1 | Lower path inversion |
| dt_load | input | 1 | Load strobe for both delay settings |
| dt_up_cfg | input | DT_W | Upper turn-on delay in cycles |
| dt_lo_cfg | input | DT_W | Lower turn-on delay in cycles |
| gate_up | output | 1 | Upper gate command |
| gate_lo | output | 1 | Lower gate command |
| short_hi | output | 2 | Short high pulse seen, per input |
| short_lo | output | 2 | Short low pulse seen, per input |
| cfg_err | output | 1 | Sticky invalid-configuration flag |

## Verification
The hardest situation to reach is a turn-on that is still pending when its input falls, so that the delay counter must be thrown away rather than finished. The bench reaches it in single buck mode: it raises pwm_a for fewer cycles than the programmed delay, then drops it, and watches the upper gate stay low throughout while the lower gate recovers one delay later. A second hard case is a delay load that must be refused: the bench issues the load while a gate is high, then measures the next turn-on delay to show that the old value is still in force.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        MODE_BUCK  = 2'd0,
        MODE_BOOST = 2'd1,
        MODE_DUAL  = 2'd2,
        MODE_RSVD  = 2'd3
    } in_mode_e;

    typedef enum logic [1:0] {
        BYP_NONE = 2'd0,
        BYP_DT   = 2'd1,
        BYP_FULL = 2'd2,
        BYP_RSVD = 2'd3
    } byp_e;

    typedef struct packed {
        logic up;
        logic lo;
    } gate_pair_t;

    // Combination of mode and bypass that must hold the stage off
    function automatic logic cfg_bad(in_mode_e m, byp_e b);
        return (m == MODE_RSVD) || (b == BYP_RSVD) ||
               ((m != MODE_DUAL) && (b != BYP_NONE));
    endfunction

    // Input routing before polarity is applied
    function automatic gate_pair_t steer(in_mode_e m, logic a, logic b);
        gate_pair_t r;
        case (m)
            MODE_BUCK:  r = '{up: a,  lo: ~a};
            MODE_BOOST: r = '{up: ~a, lo: a};
            MODE_DUAL:  r = '{up: a,  lo: b};
            default:    r = '{up: 1'b0, lo: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hbg_steer.sv
module hbg_steer
    import hbg_pkg::*;
(
    input  in_mode_e   mode_i,
    input  byp_e       byp_i,
    input  logic       inv_up,
    input  logic       inv_lo,
    input  logic       pwm_a,
    input  logic       pwm_b,
    output gate_pair_t path_o,
    output logic       use_dt_o,
    output logic       bad_o
);
    gate_pair_t routed;

    always_comb begin
        routed = steer(mode_i, pwm_a, pwm_b);
        if (byp_i == BYP_FULL) begin
            path_o = '{up: pwm_a, lo: pwm_b};
        end else begin
            path_o = '{up: routed.up ^ inv_up, lo: routed.lo ^ inv_lo};
        end
        use_dt_o = (byp_i == BYP_NONE);
        bad_o    = cfg_bad(mode_i, byp_i);
    end

endmodule

// File: rtl/hbg_turnon_delay.sv
module hbg_turnon_delay #(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold_low,
    input  logic            use_dt,
    input  logic            din,
    input  logic [DT_W-1:0] dt,
    output logic            q
);
    logic [DT_W-1:0] cnt;
    logic            expired;

    assign expired = ({1'b0, cnt} + {{DT_W{1'b0}}, 1'b1}) >= {1'b0, dt};

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (hold_low || !din) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (!use_dt) begin
            q   <= 1'b1;
            cnt <= '0;
        end else if (!q) begin
            if (expired) begin
                q <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hbg_width_mon.sv
module hbg_width_mon #(
    parameter int MIN_HI = 50,
    parameter int MIN_LO = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic short_hi,
    output logic short_lo
);
    localparam int RUN_MAX = (MIN_LO > MIN_HI) ? MIN_LO : MIN_HI;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    logic             prev;
    logic             armed;
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= 1'b0;
            armed    <= 1'b0;
            run      <= '0;
            short_hi <= 1'b0;
            short_lo <= 1'b0;
        end else begin
            short_hi <= 1'b0;
            short_lo <= 1'b0;
            prev     <= din;
            if (din != prev) begin
                if (armed && en) begin
                    short_hi <= prev  && (run < RUN_W'(MIN_HI));
                    short_lo <= !prev && (run < RUN_W'(MIN_LO));
                end
                armed <= en;
                run   <= RUN_W'(1);
            end else begin
                if (!en) armed <= 1'b0;
                if (run != RUN_W'(RUN_MAX)) run <= run + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hb_gate_cond.sv
module hb_gate_cond
    import hbg_pkg::*;
#(
    parameter int DT_W       = 6,
    parameter int DT_MIN     = 5,
    parameter int DT_MAX     = 15,
    parameter int DT_RST     = 10,
    parameter int MIN_HI_CYC = 50,
    parameter int MIN_LO_CYC = 200
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwm_a,
    input  logic            pwm_b,
    input  logic [1:0]      mode,
    input  logic [1:0]      bypass,
    input  logic            inv_up,
    input  logic            inv_lo,
    input  logic            dt_load,
    input  logic [DT_W-1:0] dt_up_cfg,
    input  logic [DT_W-1:0] dt_lo_cfg,
    output logic            gate_up,
    output logic            gate_lo,
    output logic [1:0]      short_hi,
    output logic [1:0]      short_lo,
    output logic            cfg_err
);
    localparam int NPATH = 2;   // index 0 = upper, 1 = lower
    localparam int NIN   = 2;   // index 0 = pwm_a, 1 = pwm_b

    in_mode_e   mode_e;
    byp_e       byp_v;
    gate_pair_t path;
    logic       use_dt;
    logic       bad;

    assign mode_e = in_mode_e'(mode);
    assign byp_v  = byp_e'(bypass);

    hbg_steer u_steer (
        .mode_i   (mode_e),
        .byp_i    (byp_v),
        .inv_up   (inv_up),
        .inv_lo   (inv_lo),
        .pwm_a    (pwm_a),
        .pwm_b    (pwm_b),
        .path_o   (path),
        .use_dt_o (use_dt),
        .bad_o    (bad)
    );

    function automatic logic [DT_W-1:0] clamp_dt(logic [DT_W-1:0] v);
        if (v < DT_W'(DT_MIN)) return DT_W'(DT_MIN);
        if (v > DT_W'(DT_MAX)) return DT_W'(DT_MAX);
        return v;
    endfunction

    logic [NPATH-1:0]           path_bits;
    logic [NPATH-1:0]           gate_q;
    logic [NPATH-1:0][DT_W-1:0] dt_cfg;
    logic [NPATH-1:0][DT_W-1:0] dt_q;
    logic                       load_ok;

    assign path_bits = {path.lo, path.up};
    assign dt_cfg    = {dt_lo_cfg, dt_up_cfg};
    assign load_ok   = dt_load && (gate_q == '0);

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        always_ff @(posedge clk) begin
            if (rst) begin
                dt_q[p] <= DT_W'(DT_RST);
            end else if (load_ok) begin
                dt_q[p] <= clamp_dt(dt_cfg[p]);
            end
        end

        hbg_turnon_delay #(.DT_W(DT_W)) u_dly (
            .clk      (clk),
            .rst      (rst),
            .hold_low (bad),
            .use_dt   (use_dt),
            .din      (path_bits[p]),
            .dt       (dt_q[p]),
            .q        (gate_q[p])
        );
    end

    assign gate_up = gate_q[0];
    assign gate_lo = gate_q[1];

    logic [NIN-1:0] pwm_in;
    logic [NIN-1:0] mon_en;

    assign pwm_in = {pwm_b, pwm_a};
    assign mon_en = {mode_e == MODE_DUAL, 1'b1};

    for (genvar i = 0; i < NIN; i++) begin : g_mon
        hbg_width_mon #(.MIN_HI(MIN_HI_CYC), .MIN_LO(MIN_LO_CYC)) u_mon (
            .clk      (clk),
            .rst      (rst),
            .en       (mon_en[i]),
            .din      (pwm_in[i]),
            .short_hi (short_hi[i]),
            .short_lo (short_lo[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_err <= 1'b0;
        end else if (bad) begin
            cfg_err <= 1'b1;
        end
    end

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker
    import hbg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       pwm_a,
    input logic       pwm_b,
    input logic [1:0] mode,
    input logic [1:0] bypass,
    input logic       inv_up,
    input logic       gate_up,
    input logic       gate_lo,
    input logic       cfg_err,
    input logic       inv_lo
);
    logic single_ok;
    logic dual_full;
    logic dual_cond;
    logic bad_cfg;

    assign single_ok = ((mode == MODE_BUCK) || (mode == MODE_BOOST)) &&
                       (bypass == BYP_NONE) && (inv_up == inv_lo);
    assign dual_full = (mode == MODE_DUAL) && (bypass == BYP_FULL);
    assign dual_cond = (mode == MODE_DUAL) && (bypass == BYP_NONE);
    assign bad_cfg   = (mode == MODE_RSVD) || (bypass == BYP_RSVD) ||
                       ((mode != MODE_DUAL) && (bypass != BYP_NONE));

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        (single_ok && $past(single_ok)) |-> !(gate_up && gate_lo));

    p_turnoff_fast_r6: assert property (@(posedge clk) disable iff (rst)
        (dual_cond && !(pwm_a ^ inv_up)) |=> !gate_up);

    p_full_pass_r11: assert property (@(posedge clk) disable iff (rst)
        dual_full |=> (gate_up == $past(pwm_a)) && (gate_lo == $past(pwm_b)));

    p_bad_low_r12: assert property (@(posedge clk) disable iff (rst)
        bad_cfg |=> (!gate_up && !gate_lo && cfg_err));

    p_err_hold_r12: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

endmodule

bind hb_gate_cond hbg_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .pwm_a   (pwm_a),
    .pwm_b   (pwm_b),
    .mode    (mode),
    .bypass  (bypass),
    .inv_up  (inv_up),
    .gate_up (gate_up),
    .gate_lo (gate_lo),
    .cfg_err (cfg_err),
    .inv_lo  (inv_lo)
);

// File: tb/tb_hb_gate_cond.sv
`timescale 1ns/1ps
module tb_hb_gate_cond;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_a = 1'b0, pwm_b = 1'b0;
    logic [1:0] mode = 2'd0, bypass = 2'd0;
    logic       inv_up = 1'b0, inv_lo = 1'b0;
    logic       dt_load = 1'b0;
    logic [5:0] dt_up_cfg = '0, dt_lo_cfg = '0;
    logic       gate_up, gate_lo, cfg_err;
    logic [1:0] short_hi, short_lo;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int hi_cnt [2] = '{0, 0};
    int lo_cnt [2] = '{0, 0};

    always #10 clk = ~clk;

    hb_gate_cond dut (
        .clk(clk), .rst(rst), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .mode(mode), .bypass(bypass), .inv_up(inv_up), .inv_lo(inv_lo),
        .dt_load(dt_load), .dt_up_cfg(dt_up_cfg), .dt_lo_cfg(dt_lo_cfg),
        .gate_up(gate_up), .gate_lo(gate_lo),
        .short_hi(short_hi), .short_lo(short_lo), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (short_hi[i] === 1'b1) hi_cnt[i]++;
            if (short_lo[i] === 1'b1) lo_cnt[i]++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Negedges until the selected gate is seen high (99 if never)
    task automatic wait_rise(input bit lo_sel, output int k);
        k = 99;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if ((lo_sel ? gate_lo : gate_up) === 1'b1) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic load_dt(input int up, input int lo);
        dt_up_cfg = 6'(up);
        dt_lo_cfg = 6'(lo);
        dt_load   = 1'b1;
        @(negedge clk);
        dt_load   = 1'b0;
    endtask

    task automatic t_reset();
        cyc(3);
        chk("R1", "gate_up in reset", int'(gate_up), 0);
        chk("R1", "gate_lo in reset", int'(gate_lo), 0);
        chk("R1", "cfg_err in reset", int'(cfg_err), 0);
        chk("R1", "flags in reset", int'({short_hi, short_lo}), 0);
        rst = 1'b0;
    endtask

    task automatic t_buck();
        int k;
        wait_rise(1'b1, k);
        chk("R1", "default lower delay", k, 10);
        pwm_a = 1'b1;
        @(negedge clk);
        chk("R2", "lower off one edge after pwm_a rise", int'(gate_lo), 0);
        chk("R2", "upper still held", int'(gate_up), 0);
        wait_rise(1'b0, k);
        chk("R2", "upper default delay", k + 1, 10);
        chk("R2", "lower low with upper on", int'(gate_lo), 0);
    endtask

    task automatic t_boost();
        int k;
        mode = 2'd1;
        @(negedge clk);
        chk("R3", "upper drops in boost", int'(gate_up), 0);
        wait_rise(1'b1, k);
        chk("R3", "lower takes true pwm_a", k + 1, 10);
        chk("R3", "upper low", int'(gate_up), 0);
    endtask

    task automatic t_dual_overlap();
        mode = 2'd2; pwm_a = 1'b1; pwm_b = 1'b1;
        cyc(12);
        chk("R4", "dual upper high", int'(gate_up), 1);
        chk("R4", "dual lower high together", int'(gate_lo), 1);
    endtask

    task automatic t_polarity();
        pwm_a = 1'b0; pwm_b = 1'b1; inv_up = 1'b1; inv_lo = 1'b1;
        cyc(12);
        chk("R5", "inverted upper", int'(gate_up), 1);
        chk("R5", "inverted lower", int'(gate_lo), 0);
        inv_up = 1'b0; inv_lo = 1'b0; pwm_b = 1'b0;
        cyc(2);
        chk("R5", "upper back non-inverted", int'(gate_up), 0);
    endtask

    task automatic t_dt_program();
        int k;
        load_dt(6, 12);
        pwm_a = 1'b1;
        wait_rise(1'b0, k);
        chk("R6", "upper programmed delay", k, 6);
        pwm_b = 1'b1;
        wait_rise(1'b1, k);
        chk("R6", "lower programmed delay", k, 12);
        pwm_a = 1'b0;
        @(negedge clk);
        chk("R6", "turn-off after one edge", int'(gate_up), 0);
        pwm_b = 1'b0;
        cyc(2);
    endtask

    task automatic t_clamp();
        int k;
        load_dt(2, 40);
        pwm_a = 1'b1;
        wait_rise(1'b0, k);
        chk("R7", "low setting clamped", k, 5);
        pwm_a = 1'b0; cyc(2);
        pwm_b = 1'b1;
        wait_rise(1'b1, k);
        chk("R7", "high setting clamped", k, 15);
        pwm_b = 1'b0; cyc(2);
        load_dt(10, 10);
    endtask

    task automatic t_load_ignored();
        int k;
        pwm_a = 1'b1;
        wait_rise(1'b0, k);
        chk("R8", "delay before refused load", k, 10);
        load_dt(7, 7);
        pwm_a = 1'b0; cyc(2);
        pwm_a = 1'b1;
        wait_rise(1'b0, k);
        chk("R8", "load while gate high ignored", k, 10);
        pwm_a = 1'b0; cyc(2);
    endtask

    task automatic t_cancel();
        int k, bad;
        mode = 2'd0;
        wait_rise(1'b1, k);
        chk("R9", "lower up before short pulse", k, 10);
        bad = 0;
        pwm_a = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (gate_up !== 1'b0) bad++;
            if (gate_up === 1'b1 && gate_lo === 1'b1) bad++;
        end
        pwm_a = 1'b0;
        repeat (15) begin
            @(negedge clk);
            if (gate_up !== 1'b0) bad++;
        end
        chk("R9", "cancelled turn-on never reached upper", bad, 0);
        chk("R9", "lower recovers", int'(gate_lo), 1);
    endtask

    task automatic t_dt_bypass();
        mode = 2'd2; bypass = 2'd1; inv_up = 1'b1;
        @(negedge clk);
        chk("R10", "inverted upper no delay", int'(gate_up), 1);
        inv_up = 1'b0; pwm_a = 1'b1; pwm_b = 1'b1;
        @(negedge clk);
        chk("R10", "upper follows in one edge", int'(gate_up), 1);
        chk("R10", "lower follows in one edge", int'(gate_lo), 1);
        pwm_a = 1'b0; pwm_b = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_full_bypass();
        bypass = 2'd2; inv_up = 1'b1; inv_lo = 1'b1; pwm_a = 1'b1; pwm_b = 1'b0;
        @(negedge clk);
        chk("R11", "upper copies pwm_a", int'(gate_up), 1);
        chk("R11", "lower copies pwm_b", int'(gate_lo), 0);
        pwm_a = 1'b0; pwm_b = 1'b1;
        @(negedge clk);
        chk("R11", "upper copies pwm_a low", int'(gate_up), 0);
        chk("R11", "lower copies pwm_b high", int'(gate_lo), 1);
        inv_up = 1'b0; inv_lo = 1'b0; pwm_b = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_bad_cfg();
        int k;
        mode = 2'd0; bypass = 2'd1; pwm_a = 1'b1;
        @(negedge clk);
        chk("R12", "cfg_err set", int'(cfg_err), 1);
        cyc(5);
        chk("R12", "gates held low", int'({gate_up, gate_lo}), 0);
        bypass = 2'd0;
        wait_rise(1'b0, k);
        chk("R12", "recovery after valid setting", k, 10);
        chk("R12", "cfg_err sticky", int'(cfg_err), 1);
    endtask

    task automatic t_pwm2_ignored();
        int bad, h1, l1;
        bad = 0; h1 = hi_cnt[1]; l1 = lo_cnt[1];
        for (int t = 0; t < 8; t++) begin
            pwm_b = ~pwm_b;
            repeat (3) begin
                @(negedge clk);
                if (gate_up !== 1'b1 || gate_lo !== 1'b0) bad++;
            end
        end
        pwm_b = 1'b0;
        cyc(2);
        chk("R13", "gates unchanged by pwm_b", bad, 0);
        chk("R13", "no pwm_b flag in single mode", (hi_cnt[1] - h1) + (lo_cnt[1] - l1), 0);
    endtask

    task automatic t_width();
        int h0, l0;
        mode = 2'd2; bypass = 2'd2; pwm_a = 1'b0; pwm_b = 1'b0;
        cyc(250);
        h0 = hi_cnt[0];
        pwm_a = 1'b1; cyc(10); pwm_a = 1'b0; cyc(250);
        chk("R14", "10-cycle high flagged", hi_cnt[0] - h0, 1);
        pwm_a = 1'b1; cyc(60); pwm_a = 1'b0; cyc(250);
        chk("R14", "60-cycle high not flagged", hi_cnt[0] - h0, 1);
        l0 = lo_cnt[0];
        pwm_a = 1'b1; cyc(60); pwm_a = 1'b0; cyc(50); pwm_a = 1'b1; cyc(60);
        chk("R14", "50-cycle low flagged", lo_cnt[0] - l0, 1);
        pwm_a = 1'b0; cyc(250); pwm_a = 1'b1; cyc(60); pwm_a = 1'b0; cyc(5);
        chk("R14", "250-cycle low not flagged", lo_cnt[0] - l0, 1);
    endtask

    initial begin
        t_reset();
        t_buck();
        t_boost();
        t_dual_overlap();
        t_polarity();
        t_dt_program();
        t_clamp();
        t_load_ignored();
        t_cancel();
        t_dt_bypass();
        t_full_bypass();
        t_bad_cfg();
        t_pwm2_ignored();
        t_width();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule